// File: doc/BRIEF.md
# Large-Warp Sub-Warp Formation Unit

This unit accepts the active-thread mask of one large warp, whose thread count is a whole multiple of the SIMD width, and breaks it into a series of sub-warps that each fit the fixed-width SIMD pipeline. The mask is viewed as a grid. Thread `t` sits at row `t / LANES` and column `t % LANES`. Each column feeds one SIMD lane. For every sub-warp, each column is searched on its own for its lowest-numbered active row. The threads found form the sub-warp, and they are then removed from the working copy of the mask.

Sub-warps leave through a valid/ready stream. Each sub-warp carries a lane-valid mask and a row index for every lane. The final sub-warp is flagged, and a one-cycle completion pulse follows it, so the front end knows when the large warp may be fetched again. When the instruction is an unconditional branch, the warp is not split: a single pass emits one sub-warp and finishes. An empty mask produces no sub-warp and completes at once.

Top module: `lwsw_former`

## Requirements
- R1: Thread `t` maps to row `t / LANES` and lane `t % LANES`. Bit `l` of `sw_lane_o` is 1 exactly when column `l` of the working mask still holds an active thread. Field `sw_row_o[l*RW +: RW]` then gives the lowest active row of that column, and it is 0 for an invalid lane.
- R2: Threads issued in an accepted sub-warp are cleared from the working mask. For a conditional pass, the number of sub-warps issued equals the largest count of active threads found in any single column.
- R3: `sw_last_o` is 1 on the final sub-warp of a warp and 0 on every earlier one.
- R4: `done_o` is high for one cycle, in the cycle after the final sub-warp is accepted, and it is low while a sub-warp is valid.
- R5: When `uncond_i` is 1 at load, exactly one sub-warp is issued, with `sw_last_o` = 1. Its lanes and rows follow R1 over the loaded mask.
- R6: Loading an all-zero mask produces no sub-warp, and `done_o` is high in the cycle after the load.
- R7: While `sw_valid_o` is 1 and `sw_ready_i` is 0, the valid flag and the whole payload hold steady. The next sub-warp is formed only after acceptance.
- R8: `load_i` is ignored while sub-warps of a warp are still pending.
- R9: During and right after reset, `sw_valid_o` and `done_o` are 0.
- R10: A load taken in any idle cycle, including the cycle in which `done_o` is high, presents the first sub-warp in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe to take a new large-warp mask |
| mask_i | input | LANES*ROWS | Active mask of the large warp, thread t at bit t |
| uncond_i | input | 1 | The instruction is an unconditional branch: single pass |
| sw_valid_o | output | 1 | A sub-warp is presented |
| sw_ready_i | input | 1 | The consumer accepts the sub-warp |
| sw_lane_o | output | LANES | Lane-valid mask of the sub-warp |
| sw_row_o | output | LANES*RW | Per-lane selected row index |
| sw_last_o | output | 1 | This is the final sub-warp of the warp |
| done_o | output | 1 | One-cycle pulse once the warp is fully issued |

## Verification
The hardest state to reach is a long, lopsided sequence in which one dense column keeps the warp alive after the other columns are empty, while the consumer stalls and a new load arrives in the middle. The stimulus therefore includes masks with a single full column and masks with scattered threads. It drives ready with random backpressure and inserts a load pulse while sub-warps are still pending. A behavioural model then compares every lane, row, last flag and done pulse on every clock. Back-to-back loads, issued in the very cycle that done is high, exercise the transition from idle to issue.

// File: rtl/lwsw_pkg.sv
package lwsw_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } lwsw_state_e;
endpackage

// File: rtl/lwsw_col_pick.sv
// Lowest-active-row search for one lane column.
module lwsw_col_pick #(
  parameter int ROWS = 4,
  parameter int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0] col_i,
  output logic            found_o,
  output logic [RW-1:0]   row_o,
  output logic [ROWS-1:0] hit_o
);
  always_comb begin
    row_o = '0;
    hit_o = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (col_i[r]) begin
        row_o    = RW'(r);
        hit_o    = '0;
        hit_o[r] = 1'b1;
      end
    end
  end

  assign found_o = |col_i;
endmodule

// File: rtl/lwsw_picker.sv
// Forms one sub-warp from the working mask: one search per lane column.
module lwsw_picker #(
  parameter int LANES = 8,
  parameter int ROWS  = 4,
  parameter int RW    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [LANES*ROWS-1:0] work_i,
  input  logic                  uncond_i,
  output logic [LANES-1:0]      lane_o,
  output logic [LANES*RW-1:0]   row_o,
  output logic [LANES*ROWS-1:0] clear_o,
  output logic                  rest_empty_o
);
  localparam int THREADS = LANES * ROWS;

  logic [ROWS-1:0]    col_w [LANES];
  logic [ROWS-1:0]    hit_w [LANES];
  logic [THREADS-1:0] pick_clear;
  logic [THREADS-1:0] rest;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign col_w[l][r]            = work_i[r*LANES + l];
      assign pick_clear[r*LANES + l] = hit_w[l][r];
    end

    lwsw_col_pick #(
      .ROWS (ROWS),
      .RW   (RW)
    ) u_col (
      .col_i   (col_w[l]),
      .found_o (lane_o[l]),
      .row_o   (row_o[l*RW +: RW]),
      .hit_o   (hit_w[l])
    );
  end

  // A single pass retires the whole warp when the branch is unconditional.
  assign clear_o      = uncond_i ? {THREADS{1'b1}} : pick_clear;
  assign rest         = work_i & ~clear_o;
  assign rest_empty_o = ~|rest;
endmodule

// File: rtl/lwsw_ctrl.sv
// Holds the working mask and sequences load, issue and completion.
module lwsw_ctrl
  import lwsw_pkg::*;
#(
  parameter int THREADS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [THREADS-1:0] mask_i,
  input  logic               uncond_i,
  input  logic               ready_i,
  input  logic [THREADS-1:0] clear_i,
  input  logic               rest_empty_i,
  output logic               valid_o,
  output logic [THREADS-1:0] work_o,
  output logic               uncond_o,
  output logic               done_o
);
  lwsw_state_e        state_q, state_d;
  logic [THREADS-1:0] work_q, work_d;
  logic               unc_q, unc_d;
  logic               done_q, done_d;
  logic               work_en;
  logic               unc_en;

  always_comb begin
    state_d = state_q;
    work_d  = work_q;
    unc_d   = unc_q;
    done_d  = 1'b0;
    work_en = 1'b0;
    unc_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          if (|mask_i) begin
            state_d = ST_ISSUE;
            work_d  = mask_i;
            unc_d   = uncond_i;
            work_en = 1'b1;
            unc_en  = 1'b1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (ready_i) begin
          work_en = 1'b1;
          if (rest_empty_i) begin
            state_d = ST_IDLE;
            work_d  = '0;
            done_d  = 1'b1;
          end else begin
            work_d = work_q & ~clear_i;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unc_q <= 1'b0;
    end else if (unc_en) begin
      unc_q <= unc_d;
    end
  end

  assign valid_o  = (state_q == ST_ISSUE);
  assign work_o   = work_q;
  assign uncond_o = unc_q;
  assign done_o   = done_q;
endmodule

// File: rtl/lwsw_former.sv
module lwsw_former #(
  parameter int LANES   = 8,
  parameter int ROWS    = 4,
  localparam int THREADS = LANES * ROWS,
  localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [THREADS-1:0]  mask_i,
  input  logic                uncond_i,
  output logic                sw_valid_o,
  input  logic                sw_ready_i,
  output logic [LANES-1:0]    sw_lane_o,
  output logic [LANES*RW-1:0] sw_row_o,
  output logic                sw_last_o,
  output logic                done_o
);
  logic [THREADS-1:0] work;
  logic [THREADS-1:0] clear;
  logic               unc;
  logic               rest_empty;
  logic               valid;

  lwsw_ctrl #(
    .THREADS (THREADS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .mask_i       (mask_i),
    .uncond_i     (uncond_i),
    .ready_i      (sw_ready_i),
    .clear_i      (clear),
    .rest_empty_i (rest_empty),
    .valid_o      (valid),
    .work_o       (work),
    .uncond_o     (unc),
    .done_o       (done_o)
  );

  lwsw_picker #(
    .LANES (LANES),
    .ROWS  (ROWS),
    .RW    (RW)
  ) u_pick (
    .work_i       (work),
    .uncond_i     (unc),
    .lane_o       (sw_lane_o),
    .row_o        (sw_row_o),
    .clear_o      (clear),
    .rest_empty_o (rest_empty)
  );

  assign sw_valid_o = valid;
  assign sw_last_o  = valid & rest_empty;
endmodule

// File: rtl/lwsw_former_chk.sv
module lwsw_former_chk #(
  parameter int LANES = 8,
  parameter int ROWS  = 4,
  localparam int THREADS = LANES * ROWS,
  localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_i,
  input logic [THREADS-1:0]  mask_i,
  input logic                uncond_i,
  input logic                sw_valid_o,
  input logic                sw_ready_i,
  input logic [LANES-1:0]    sw_lane_o,
  input logic [LANES*RW-1:0] sw_row_o,
  input logic                sw_last_o,
  input logic                done_o
);
  p_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid_o |-> (|sw_lane_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid_o && !sw_ready_i) |=> (sw_valid_o && $stable(sw_lane_o)
      && $stable(sw_row_o) && $stable(sw_last_o)));

  p_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid_o && sw_ready_i && sw_last_o) |=> (done_o && !sw_valid_o));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sw_valid_o);

  p_more_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid_o && sw_ready_i && !sw_last_o) |=> (sw_valid_o && !done_o));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !sw_valid_o && uncond_i && (|mask_i)) |=> (sw_valid_o && sw_last_o));

  p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !sw_valid_o && !(|mask_i)) |=> (done_o && !sw_valid_o));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid_o && load_i && !(sw_ready_i && sw_last_o)) |=> sw_valid_o);
endmodule

bind lwsw_former lwsw_former_chk #(
  .LANES (LANES),
  .ROWS  (ROWS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .mask_i     (mask_i),
  .uncond_i   (uncond_i),
  .sw_valid_o (sw_valid_o),
  .sw_ready_i (sw_ready_i),
  .sw_lane_o  (sw_lane_o),
  .sw_row_o   (sw_row_o),
  .sw_last_o  (sw_last_o),
  .done_o     (done_o)
);

// File: tb/lwsw_former_tb.sv
module lwsw_former_tb;
  localparam int LANES   = 8;
  localparam int ROWS    = 4;
  localparam int THREADS = LANES * ROWS;
  localparam int RW      = 2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                load_i;
  logic [THREADS-1:0]  mask_i;
  logic                uncond_i;
  logic                sw_valid_o;
  logic                sw_ready_i;
  logic [LANES-1:0]    sw_lane_o;
  logic [LANES*RW-1:0] sw_row_o;
  logic                sw_last_o;
  logic                done_o;

  always #10 clk = ~clk;

  lwsw_former #(.LANES(LANES), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .mask_i(mask_i),
    .uncond_i(uncond_i), .sw_valid_o(sw_valid_o), .sw_ready_i(sw_ready_i),
    .sw_lane_o(sw_lane_o), .sw_row_o(sw_row_o), .sw_last_o(sw_last_o),
    .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int acc_cnt = 0;

  // behavioural model state
  bit [THREADS-1:0] m_work;
  bit               m_busy;
  bit               m_unc;
  bit               m_done;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_pick(input bit [THREADS-1:0] w, input bit unc,
                            output bit [LANES-1:0] lane, output bit [LANES*RW-1:0] rows,
                            output bit [THREADS-1:0] rest);
    lane = '0;
    rows = '0;
    rest = w;
    for (int l = 0; l < LANES; l++) begin
      for (int r = 0; r < ROWS; r++) begin
        if (!lane[l] && w[r*LANES + l]) begin
          lane[l] = 1'b1;
          rows[l*RW +: RW] = RW'(r);
          rest[r*LANES + l] = 1'b0;
        end
      end
    end
    if (unc) rest = '0;
  endtask

  function automatic int exp_count(input bit [THREADS-1:0] m, input bit unc);
    int best = 0;
    if (m == '0) return 0;
    if (unc) return 1;
    for (int l = 0; l < LANES; l++) begin
      int c = 0;
      for (int r = 0; r < ROWS; r++) c += int'(m[r*LANES + l]);
      if (c > best) best = c;
    end
    return best;
  endfunction

  // model update on each edge, comparison a quarter period later
  always @(posedge clk or negedge rst_n) begin
    bit [LANES-1:0]    e_lane;
    bit [LANES*RW-1:0] e_rows;
    bit [THREADS-1:0]  e_rest;
    bit                nd;
    if (!rst_n) begin
      m_work = '0; m_busy = 0; m_unc = 0; m_done = 0;
    end else begin
      nd = 0;
      if (m_busy && sw_ready_i) begin
        acc_cnt++;
        model_pick(m_work, m_unc, e_lane, e_rows, e_rest);
        if (e_rest == '0) begin
          m_busy = 0; m_work = '0; nd = 1;
        end else begin
          m_work = e_rest;
        end
      end else if (!m_busy && load_i) begin
        if (mask_i == '0) nd = 1;
        else begin
          m_busy = 1; m_work = mask_i; m_unc = uncond_i;
        end
      end
      m_done = nd;
      #5;
      model_pick(m_work, m_unc, e_lane, e_rows, e_rest);
      chk(sw_valid_o == m_busy, "R7 valid", sw_valid_o, m_busy);
      chk(done_o == m_done, "R4 done", done_o, m_done);
      if (m_busy) begin
        chk(sw_lane_o == e_lane, "R1 lanes", sw_lane_o, e_lane);
        chk(sw_row_o == e_rows, "R1 rows", sw_row_o, e_rows);
        chk(sw_last_o == (e_rest == '0), "R3 last", sw_last_o, (e_rest == '0));
      end
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0:       sw_ready_i <= 1'b1;
      1:       sw_ready_i <= 1'($urandom % 2);
      default: sw_ready_i <= (($urandom % 4) == 0);
    endcase
  end

  // starts at a negedge; returns at the negedge where done_o is seen
  task automatic run_case(input bit [THREADS-1:0] m, input bit unc, input int rmode,
                          input string req, input bit mid_load);
    int  start;
    bit  seen;
    ready_mode = rmode;
    start = acc_cnt;
    load_i = 1'b1; mask_i = m; uncond_i = unc;
    @(negedge clk);
    load_i = 1'b0; uncond_i = 1'b0;
    if (m != '0) chk(sw_valid_o == 1'b1, "R10 first sub-warp", sw_valid_o, 1);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done_o) seen = 1;
      else begin
        if (mid_load && i == 1) begin
          load_i = 1'b1; mask_i = ~m;
        end else begin
          load_i = 1'b0;
        end
        @(negedge clk);
      end
    end
    load_i = 1'b0;
    chk(seen, "R4 done seen", seen, 1);
    chk((acc_cnt - start) == exp_count(m, unc), req, acc_cnt - start, exp_count(m, unc));
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; mask_i = '0; uncond_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sw_valid_o == 1'b0 && done_o == 1'b0, "R9 reset state", {sw_valid_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw_valid_o == 1'b0 && done_o == 1'b0, "R9 after reset", {sw_valid_o, done_o}, 0);

    run_case({THREADS{1'b1}}, 1'b0, 0, "R2 full mask count", 1'b0);
    run_case(32'h0101_0101, 1'b0, 0, "R2 dense column count", 1'b0);
    run_case(32'h0000_0400, 1'b0, 0, "R2 single thread count", 1'b0);
    run_case(32'h8421_1248, 1'b0, 1, "R2 scattered with backpressure", 1'b0);
    run_case(32'h0000_0000, 1'b0, 0, "R6 empty mask", 1'b0);
    run_case(32'hF0F0_0F0F, 1'b1, 1, "R5 unconditional single pass", 1'b0);
    run_case(32'h0000_0000, 1'b1, 0, "R6 empty unconditional", 1'b0);
    run_case(32'h1111_1111, 1'b0, 2, "R8 load while pending", 1'b1);
    run_case(32'hFFFF_0001, 1'b0, 2, "R7 heavy stall", 1'b0);
    for (int k = 0; k < 40; k++) begin
      bit [THREADS-1:0] m;
      m = $urandom;
      if (k % 3 == 0) m = m & $urandom;
      run_case(m, bit'(k % 5 == 4), k % 3, "R2 random mask count", bit'(k % 4 == 1));
    end
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule